// File: doc/BRIEF.md
# Transmit Channel-to-DAC Router

This block sits between the host sample stream and the four DAC ports of a transmitter. Host words arrive one at a time on a 16-bit valid/ready stream and are sorted into the real and imaginary parts of one or two complex channels. The `two_chan` input sets the channel count. Once every word of a sample set has arrived, all four DAC outputs update in the same cycle, and a one-cycle strobe marks the update.

A 32-bit routing word decides what each DAC port carries. The word gives each DAC its own 4-bit field, made of an enable bit and a 3-bit source code. The source code picks one of the four real channel components. A DAC that is switched off carries zero. A DAC that is switched on but has a meaningless source code also carries zero, and it raises an error flag. A new routing word never takes effect in the middle of a sample set.

Back-pressure: `in_ready` is low while reset is asserted. It rises on the first clock after reset is released and then stays high. A word is accepted on each rising edge where both `in_valid` and `in_ready` are high. The source may leave `in_valid` low for any number of cycles, either between the words of a set or between sets.

Top module: `tx_dac_router`

## Requirements
- R1: While reset is asserted, `in_ready` is low, all DAC outputs are zero, and `dac_stb` and `cfg_err` are low. Reset clears every DAC enable, so a sample set sent before any routing write drives zero on all four outputs. `in_ready` is high from the first clock after reset is released.
- R2: DAC k is controlled by routing bits 4k+3 down to 4k, for k = 0 to 3. Bits 31:16 of the routing word have no effect.
- R3: Inside each 4-bit field, bit 3 enables the DAC and bits 2:0 form the source code. Code 0 selects channel 0 real, code 1 selects channel 0 imaginary, code 2 selects channel 1 real and code 3 selects channel 1 imaginary.
- R4: A DAC whose enable bit is 0 outputs zero, whatever its source code.
- R5: An enabled DAC with a source code from 4 to 7 outputs zero. At that update `cfg_err` goes high. At each strobe, `cfg_err` is updated to show whether the routing used for that set had any such DAC.
- R6: With `two_chan`=1, a set is four accepted words, in the order ch0 real, ch0 imag, ch1 real, ch1 imag. All four outputs update, and `dac_stb` is high for exactly one cycle, in the cycle after the last word of the set is accepted.
- R7: With `two_chan`=0, a set is two accepted words, ch0 real then ch0 imag. In this mode, source codes 2 and 3 give zero.
- R8: `two_chan` is sampled together with the first word of each set. Changing it in the middle of a set has no effect until the next set.
- R9: Each set is routed with the routing word held in the cycle its last word is accepted. A routing write made in that same cycle applies from the next set onward. Between strobes, the outputs and `cfg_err` hold their values.
- R10: A cycle in which `in_valid` is low accepts no word, and the data bus is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 16 | Host sample word |
| in_valid | input | 1 | Host word is valid |
| in_ready | output | 1 | Router can accept a word |
| two_chan | input | 1 | 1 = two complex channels, 0 = one |
| cfg_we | input | 1 | Write strobe for the routing word |
| cfg_wdata | input | 32 | Routing word |
| dac0 | output | 16 | DAC port 0 sample |
| dac1 | output | 16 | DAC port 1 sample |
| dac2 | output | 16 | DAC port 2 sample |
| dac3 | output | 16 | DAC port 3 sample |
| dac_stb | output | 1 | One-cycle pulse when the DAC outputs update |
| cfg_err | output | 1 | The routing used for the last set had an illegal source |

## Verification
The hardest case to reach is the set boundary, where the channel count, a routing write and the last word of a set all meet. The stimulus covers it in several ways:
- It toggles `two_chan` after the first word of a set.
- It places routing writes on a middle word of a set, and also on the final word.
- It inserts random idle gaps with garbage on the data bus.

It then runs several hundred random sets with random routing words, including illegal source codes. Each set is checked against a model that applies each write at the set it belongs to.

// File: rtl/tx_route_pkg.sv
package tx_route_pkg;
  localparam int NUM_DAC  = 4;
  localparam int NUM_SRC  = 4;
  localparam int FIELD_W  = 4;
  localparam int CODE_W   = FIELD_W - 1;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int MAP_W    = NUM_DAC * FIELD_W;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } dac_field_t;
endpackage

// File: rtl/txr_collect.sv
module txr_collect #(
  parameter int W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [W-1:0]                         in_data,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic                                 two_chan,
  output logic                                 set_done,
  output logic [tx_route_pkg::NUM_SRC-1:0][W-1:0] set_words
);
  import tx_route_pkg::*;
  localparam int IDX_W = SEL_W;

  logic                       rdy_q;
  logic [IDX_W-1:0]           idx_q;
  logic                       two_q;
  logic [NUM_SRC-1:0][W-1:0]  hold_q;
  logic                       accept;
  logic                       two_now;
  logic [IDX_W-1:0]           last_idx;

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;
  assign two_now  = (idx_q == '0) ? two_chan : two_q;
  assign last_idx = two_now ? IDX_W'(NUM_SRC - 1) : IDX_W'(NUM_SRC / 2 - 1);
  assign set_done = accept && (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      idx_q  <= '0;
      two_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (accept) begin
        hold_q[idx_q] <= in_data;
        if (idx_q == '0) two_q <= two_chan;
        idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_word
    always_comb begin
      if (!two_now && i >= NUM_SRC / 2)
        set_words[i] = '0;
      else if (idx_q == IDX_W'(i))
        set_words[i] = in_data;
      else
        set_words[i] = hold_q[i];
    end
  end
endmodule

// File: rtl/txr_lane.sv
module txr_lane #(
  parameter int W = 16
) (
  input  tx_route_pkg::dac_field_t                  field,
  input  logic [tx_route_pkg::NUM_SRC-1:0][W-1:0]   words,
  output logic [W-1:0]                              sample,
  output logic                                      illegal
);
  import tx_route_pkg::*;
  logic legal;

  assign legal   = (field.code < CODE_W'(NUM_SRC));
  assign illegal = field.en && !legal;
  assign sample  = (field.en && legal) ? words[field.code[SEL_W-1:0]] : '0;
endmodule

// File: rtl/tx_dac_router.sv
module tx_dac_router #(
  parameter int W     = 16,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             two_chan,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [W-1:0]     dac0,
  output logic [W-1:0]     dac1,
  output logic [W-1:0]     dac2,
  output logic [W-1:0]     dac3,
  output logic             dac_stb,
  output logic             cfg_err
);
  import tx_route_pkg::*;

  logic [MAP_W-1:0]                map_q;
  logic                            set_done;
  logic [NUM_SRC-1:0][W-1:0]       set_words;
  logic [NUM_DAC-1:0][W-1:0]       lane_out;
  logic [NUM_DAC-1:0]              lane_bad;
  logic [NUM_DAC-1:0][W-1:0]       dac_q;
  logic                            stb_q;
  logic                            err_q;

  txr_collect #(.W(W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .two_chan (two_chan),
    .set_done (set_done),
    .set_words(set_words)
  );

  for (genvar k = 0; k < NUM_DAC; k++) begin : g_lane
    txr_lane #(.W(W)) u_lane (
      .field  (dac_field_t'(map_q[k*FIELD_W +: FIELD_W])),
      .words  (set_words),
      .sample (lane_out[k]),
      .illegal(lane_bad[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      dac_q <= '0;
      stb_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (cfg_we) map_q <= cfg_wdata[MAP_W-1:0];
      stb_q <= set_done;
      if (set_done) begin
        dac_q <= lane_out;
        err_q <= |lane_bad;
      end
    end
  end

  assign dac0    = dac_q[0];
  assign dac1    = dac_q[1];
  assign dac2    = dac_q[2];
  assign dac3    = dac_q[3];
  assign dac_stb = stb_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/tx_dac_router_chk.sv
module tx_dac_router_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [15:0]  map_q,
  input logic [W-1:0] dac0,
  input logic [W-1:0] dac3,
  input logic         dac_stb,
  input logic         cfg_err
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_ready_low_in_reset: assert (!in_ready);
  end

  a_r6_stb_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dac_stb |-> $past(in_valid && in_ready));

  a_r4_dac0_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_stb && !$past(map_q[3])) |-> (dac0 == '0));

  a_r4_dac3_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_stb && !$past(map_q[15])) |-> (dac3 == '0));

  a_r5_err_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> dac_stb);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_stb |-> ($stable(dac0) && $stable(dac3) && $stable(cfg_err)));
endmodule

bind tx_dac_router tx_dac_router_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .map_q   (map_q),
  .dac0    (dac0),
  .dac3    (dac3),
  .dac_stb (dac_stb),
  .cfg_err (cfg_err)
);

// File: tb/tx_dac_router_test.sv
module tx_dac_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        two_chan = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] dac0, dac1, dac2, dac3;
  logic        dac_stb, cfg_err;

  int errors = 0;
  int checks = 0;
  logic [15:0] cfg_model = '0;
  logic [15:0] wv [4];
  logic [15:0] last_out [4];
  logic        last_err;
  bit          done = 0;

  always #4 clk = ~clk;

  tx_dac_router uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .two_chan(two_chan), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .dac0(dac0), .dac1(dac1), .dac2(dac2),
    .dac3(dac3), .dac_stb(dac_stb), .cfg_err(cfg_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_out(logic [15:0] cfg, int k, bit two);
    logic [3:0] f = cfg[4*k +: 4];
    if (!f[3] || f[2]) return 16'h0;
    if (!two && f[1]) return 16'h0;
    return wv[f[1:0]];
  endfunction

  function automatic logic exp_err(logic [15:0] cfg);
    logic e = 1'b0;
    for (int k = 0; k < 4; k++) if (cfg[4*k+3] && cfg[4*k+2]) e = 1'b1;
    return e;
  endfunction

  function automatic logic [15:0] dac_of(int k);
    case (k)
      0: return dac0;
      1: return dac1;
      2: return dac2;
      default: return dac3;
    endcase
  endfunction

  task automatic write_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = $urandom;
    cfg_model = v[15:0];
  endtask

  // Called at a falling edge. wr_at: word index carrying a routing write (-1 none).
  task automatic run_set(string tag, bit two, bit toggle, int wr_at,
                         logic [31:0] wr_val, int max_gap);
    int n = two ? 4 : 2;
    logic [15:0] use_cfg;
    for (int i = 0; i < 4; i++) wv[i] = $urandom;
    use_cfg = cfg_model;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && max_gap > 0) begin
        int gap = $urandom_range(max_gap, 0);
        repeat (gap) begin
          in_data = $urandom; two_chan = $urandom;  // R10 idle garbage
          @(negedge clk);
        end
      end
      in_valid = 1'b1; in_data = wv[i];
      two_chan = (i == 0) ? two : (toggle ? ~two : two);
      if (i == wr_at) begin
        cfg_we = 1'b1; cfg_wdata = wr_val;
        if (i < n - 1) use_cfg = wr_val[15:0];
      end
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
    end
    if (wr_at >= 0) cfg_model = wr_val[15:0];
    check({tag, " R6 strobe"}, dac_stb, 1);
    for (int k = 0; k < 4; k++) begin
      last_out[k] = exp_out(use_cfg, k, two);
      check({tag, " dac"}, dac_of(k), last_out[k]);
    end
    last_err = exp_err(use_cfg);
    check({tag, " R5 err"}, cfg_err, last_err);
    @(negedge clk);
    check("R6 strobe one cycle", dac_stb, 0);
    for (int k = 0; k < 4; k++) check("R9 hold", dac_of(k), last_out[k]);
    check("R9 err hold", cfg_err, last_err);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 ready low", in_ready, 0);
    check("R1 stb", dac_stb, 0);
    check("R1 err", cfg_err, 0);
    check("R1 dac0", dac0, 0);
    check("R1 dac3", dac3, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready high", in_ready, 1);
    run_set("R1 enables clear", 1, 0, -1, 0, 0);
    write_cfg(32'hFFFF_BA98);
    run_set("R2 R3 identity map", 1, 0, -1, 0, 0);
    write_cfg(32'h0000_89AB);
    run_set("R3 reversed map", 1, 0, -1, 0, 2);
    write_cfg(32'h0000_0123);
    run_set("R4 all disabled", 1, 0, -1, 0, 0);
    write_cfg(32'h1234_8C98);
    run_set("R5 illegal code", 1, 0, -1, 0, 0);
    write_cfg(32'h0000_BA98);
    run_set("R5 err clears", 1, 0, -1, 0, 0);
    run_set("R7 one channel", 0, 0, -1, 0, 0);
    run_set("R8 toggle after first one", 0, 1, -1, 0, 0);
    run_set("R8 toggle after first two", 1, 1, -1, 0, 1);
    run_set("R9 write mid set", 1, 0, 1, 32'h0000_9898, 0);
    run_set("R9 write on last", 1, 0, 3, 32'h0000_A8B9, 0);
    run_set("R9 next set new cfg", 1, 0, -1, 0, 0);
    for (int s = 0; s < 300; s++) begin
      bit two = $urandom;
      int wr_at = ($urandom_range(3, 0) == 0) ? $urandom_range(two ? 3 : 1, 0) : -1;
      run_set("R10 random", two, $urandom_range(1, 0), wr_at, $urandom, 3);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule